// File: doc/BRIEF.md
# Multi-Context Atomic Reservation Monitor

This block keeps the load-reserved / store-conditional reservations for a set of hardware contexts that share one memory. Each cycle it may accept one memory request made of a context number, a physical address, an operation code and an uncacheable flag. A locked load records a reservation for its context. A store-conditional is checked against the reservation of the context that issues it. Any store that really writes knocks out the reservations of every context that watches the same 16-byte granule.

For every request, the block returns a registered write-enable one cycle later. For every cacheable store-conditional it also returns a pass/fail result. Each context has its own count of consecutive store-conditional failures. A one-cycle warning pulse, tagged with the context number, fires every time that count reaches a further multiple of a programmable period. This lets a system spot a context that is livelocked.

Top module: `rsv_monitor`

## Requirements
- R1: A locked load (op code 1) from context c writes the request address into c's reservation and sets c's reservation flag. A later locked load from c replaces the address and keeps the flag set.
- R2: Two addresses match when their bits above bit 3 are equal. Every address in one aligned 16-byte granule is therefore treated as the same location.
- R3: A cacheable store-conditional (op code 2, uncacheable low) passes only when the issuer's flag is set and its reserved granule matches the store granule. The block then drives sc_valid high, sc_pass equal to that outcome, and wr_en equal to sc_pass.
- R4: A failing cacheable store-conditional clears only the issuer's flag and adds one to the issuer's failure count. It leaves every other context's reservation intact and performs no write.
- R5: A passing cacheable store-conditional sets the issuer's failure count to zero.
- R6: An uncacheable store-conditional always writes (wr_en high). It leaves sc_valid low and sc_pass holding its previous value, sets the issuer's failure count to zero, and acts as a store under R7.
- R7: Every write clears the flag of every context, the issuer included, whose reserved granule matches the write address. A write is an ordinary store (op code 3, wr_en high), a passing store-conditional, or an uncacheable store-conditional.
- R8: warn pulses for one cycle, with warn_ctx naming the context, each time a failure count reaches a nonzero multiple of WARN_PERIOD (default 100000).
- R9: Synchronous reset clears all flags, reserved addresses, failure counts and outputs.
- R10: Outputs are registered one clock after the request, and state changes on that same edge. Op code 0 and cycles with req_valid low change no state and leave sc_valid, wr_en and warn low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_ctx | input | CTX_W | Issuing context number |
| req_addr | input | ADDR_W | Physical address |
| req_op | input | 2 | 0 other, 1 locked load, 2 store-conditional, 3 store |
| req_uncached | input | 1 | Request targets uncacheable space |
| sc_valid | output | 1 | sc_pass carries a fresh store-conditional result |
| sc_pass | output | 1 | Store-conditional outcome |
| wr_en | output | 1 | The request performs its write |
| warn | output | 1 | Failure-count warning pulse |
| warn_ctx | output | CTX_W | Context that raised warn |

## Verification
The bench sweeps every ordered pair of contexts against granule offsets on both sides of a 16-byte boundary. A design that compared bit 3, or the full address, would pass or fail the wrong store-conditionals. It checks that a failed attempt from one context leaves a neighbour's reservation standing, which catches a design that invalidates on failure. It checks that a passing store-conditional also clears the issuer's own flag, which catches a design where a second attempt wrongly succeeds. It drives runs of failures that are broken by passes and by uncacheable attempts, and expects warn only on exact multiples of a small WARN_PERIOD. A counter that was not reset, or a residue that was off by one, would therefore pulse early, pulse late, or not pulse at all.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        OP_OTHER  = 2'd0,
        OP_LDLOCK = 2'd1,
        OP_STCOND = 2'd2,
        OP_STORE  = 2'd3
    } mem_op_e;

    localparam int GRAN_LSB = 4;

    typedef struct packed {
        logic ld_lock;
        logic st_cond;
        logic st_plain;
        logic uncached;
    } req_kind_t;

    function automatic logic same_granule(input logic [63:0] a, input logic [63:0] b);
        return a[63:GRAN_LSB] == b[63:GRAN_LSB];
    endfunction

endpackage

// File: rtl/rsv_decode.sv
module rsv_decode
    import rsv_pkg::*;
(
    input  logic      valid,
    input  logic [1:0] op,
    input  logic      uncached,
    output req_kind_t kind
);
    mem_op_e op_e;

    always_comb begin
        op_e          = mem_op_e'(op);
        kind          = '0;
        kind.uncached = valid && uncached;
        if (valid) begin
            unique case (op_e)
                OP_LDLOCK: kind.ld_lock  = 1'b1;
                OP_STCOND: kind.st_cond  = 1'b1;
                OP_STORE:  kind.st_plain = 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/rsv_slot.sv
module rsv_slot
    import rsv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              flag_o,
    output logic              gran_hit_o
);
    logic [ADDR_W-1:0] addr_q;
    logic              flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            flag_q <= 1'b0;
        end else if (set_i) begin
            addr_q <= addr_i;
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o     = flag_q;
    assign gran_hit_o = same_granule(64'(addr_q), 64'(addr_i));

    AST_LL_SETS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> (flag_q && addr_q == $past(addr_i))); // R1
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_q); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> ($stable(flag_q) && $stable(addr_q))); // R10
endmodule

// File: rtl/rsv_fail_track.sv
module rsv_fail_track #(
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic inc_i,
    input  logic clr_i,
    output logic hit_o
);
    localparam int RES_W = $clog2(WARN_PERIOD + 1);
    localparam logic [RES_W-1:0] RES_TOP = RES_W'(WARN_PERIOD - 1);

    logic [CNT_W-1:0] count_q;
    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            count_q <= '0;
            res_q   <= '0;
        end else if (inc_i) begin
            count_q <= count_q + 1'b1;
            res_q   <= (res_q == RES_TOP) ? '0 : res_q + 1'b1;
        end
    end

    assign hit_o = inc_i && (res_q == RES_TOP);

    AST_FAIL_CLR: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (count_q == '0 && res_q == '0)); // R5
    AST_FAIL_INC: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i) |=> (count_q == $past(count_q) + 1'b1)); // R4
    AST_RES_RANGE: assert property (@(posedge clk) disable iff (rst)
        res_q <= RES_TOP); // R8
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter int N_CTX       = 4,
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000,
    localparam int CTX_W      = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_op,
    input  logic              req_uncached,
    output logic              sc_valid,
    output logic              sc_pass,
    output logic              wr_en,
    output logic              warn,
    output logic [CTX_W-1:0]  warn_ctx
);
    req_kind_t        kind;
    logic [N_CTX-1:0] sel, flag, gran, slot_clr, hit;
    logic             own_flag, own_gran;
    logic             sc_cached, sc_ok, sc_bad, do_write;

    rsv_decode u_dec (
        .valid    (req_valid),
        .op       (req_op),
        .uncached (req_uncached),
        .kind     (kind)
    );

    always_comb begin
        own_flag = 1'b0;
        own_gran = 1'b0;
        for (int i = 0; i < N_CTX; i++) begin
            if (sel[i]) begin
                own_flag = flag[i];
                own_gran = gran[i];
            end
        end
    end

    assign sc_cached = kind.st_cond && !kind.uncached;
    assign sc_ok     = sc_cached && own_flag && own_gran;
    assign sc_bad    = sc_cached && !(own_flag && own_gran);
    assign do_write  = kind.st_plain || (kind.st_cond && kind.uncached) || sc_ok;

    for (genvar g = 0; g < N_CTX; g++) begin : g_ctx
        assign sel[g]      = (req_ctx == CTX_W'(g));
        assign slot_clr[g] = (do_write && gran[g]) || (sel[g] && sc_bad);

        rsv_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .set_i      (sel[g] && kind.ld_lock),
            .clr_i      (slot_clr[g]),
            .addr_i     (req_addr),
            .flag_o     (flag[g]),
            .gran_hit_o (gran[g])
        );

        rsv_fail_track #(.CNT_W(CNT_W), .WARN_PERIOD(WARN_PERIOD)) u_fail (
            .clk   (clk),
            .rst   (rst),
            .inc_i (sel[g] && sc_bad),
            .clr_i (sel[g] && kind.st_cond && !sc_bad),
            .hit_o (hit[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_valid <= 1'b0;
            sc_pass  <= 1'b0;
            wr_en    <= 1'b0;
            warn     <= 1'b0;
            warn_ctx <= '0;
        end else begin
            sc_valid <= sc_cached;
            if (sc_cached) sc_pass <= sc_ok;
            wr_en    <= do_write;
            warn     <= |hit;
            if (|hit) warn_ctx <= req_ctx;
        end
    end

    AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && !sc_pass) |-> !wr_en); // R4
    AST_PASS_WRITES: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && sc_pass) |-> wr_en); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!sc_valid && !wr_en && !warn)); // R10
    AST_WARN_ONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)); // R8
    AST_UNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (kind.st_cond && kind.uncached) |=> (!sc_valid && wr_en && $stable(sc_pass))); // R6
endmodule

// File: tb/rsv_monitor_tb.sv
module rsv_monitor_tb;
    localparam int N  = 4;
    localparam int AW = 12;
    localparam int WP = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [1:0]    req_ctx;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_op;
    logic          req_uncached;
    logic          sc_valid, sc_pass, wr_en, warn;
    logic [1:0]    warn_ctx;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic          m_flag [N];
    logic [AW-1:0] m_addr [N];
    int            m_fcnt [N];
    logic          m_pass;

    always #2 clk = ~clk;

    rsv_monitor #(.N_CTX(N), .ADDR_W(AW), .CNT_W(32), .WARN_PERIOD(WP)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ctx(req_ctx),
        .req_addr(req_addr), .req_op(req_op), .req_uncached(req_uncached),
        .sc_valid(sc_valid), .sc_pass(sc_pass), .wr_en(wr_en),
        .warn(warn), .warn_ctx(warn_ctx)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual{valid,pass,wr,warn,wctx}=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic inval(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++)
            if (m_addr[i][AW-1:4] == a[AW-1:4]) m_flag[i] = 1'b0;
    endtask

    // called at a negedge; returns at the negedge after the request edge
    task automatic req(input string tag, input int c, input logic [AW-1:0] a,
                       input logic [1:0] op, input logic unc);
        logic ev, ew, ewn, ok;
        logic [1:0] ewc;
        ev = 0; ew = 0; ewn = 0; ewc = 0;
        req_valid = 1; req_ctx = 2'(c); req_addr = a; req_op = op; req_uncached = unc;
        @(posedge clk);
        case (op)
            2'd1: begin m_flag[c] = 1; m_addr[c] = a; end
            2'd2: if (unc) begin
                ew = 1; m_fcnt[c] = 0; inval(a);
            end else begin
                ok = m_flag[c] && (m_addr[c][AW-1:4] == a[AW-1:4]);
                ev = 1; m_pass = ok;
                if (ok) begin ew = 1; m_fcnt[c] = 0; inval(a); end
                else begin
                    m_flag[c] = 0; m_fcnt[c]++;
                    if (m_fcnt[c] % WP == 0) begin ewn = 1; ewc = 2'(c); end
                end
            end
            2'd3: begin ew = 1; inval(a); end
            default: ;
        endcase
        @(negedge clk);
        req_valid = 0;
        check(tag, {sc_valid, sc_pass, wr_en, warn, (warn ? warn_ctx : 2'b00)},
                   {ev, m_pass, ew, ewn, ewc});
    endtask

    initial begin
        #200000;
        $display("FAIL watchdog expired");
        fails++;
        checks++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; req_valid = 0; req_ctx = 0; req_addr = 0; req_op = 0; req_uncached = 0;
        m_pass = 0;
        for (int i = 0; i < N; i++) begin m_flag[i] = 0; m_addr[i] = 0; m_fcnt[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        check("R9 reset outputs", {sc_valid, sc_pass, wr_en, warn, warn_ctx}, 6'b0);
        for (int c = 0; c < N; c++) req("R9 no reservation after reset", c, 12'h000, 2'd2, 0);

        // R2/R3: every ordered context pair across granule offsets
        for (int c1 = 0; c1 < N; c1++)
            for (int c2 = 0; c2 < N; c2++)
                for (int k = 0; k < 6; k++) begin
                    int offs [6] = '{0, 3, 8, 15, 16, 31};
                    req("R1 locked load", c1, 12'h140 + 12'(c1), 2'd1, 0);
                    req("R2 R3 granule compare", c2, 12'h140 + 12'(offs[k]), 2'd2, 0);
                    req("R7 issuer cleared after pass", c1, 12'h140, 2'd2, 0);
                end

        // R4: failure from one context leaves a neighbour intact
        req("R1", 0, 12'h200, 2'd1, 0);
        req("R1", 1, 12'h204, 2'd1, 0);
        req("R4 fail own", 0, 12'h300, 2'd2, 0);
        req("R4 neighbour survives", 1, 12'h20F, 2'd2, 0);

        // R1 replace
        req("R1", 2, 12'h400, 2'd1, 0);
        req("R1 replace", 2, 12'h500, 2'd1, 0);
        req("R1 old address lost", 2, 12'h400, 2'd2, 0);
        req("R1", 2, 12'h500, 2'd1, 0);
        req("R1 new address passes", 2, 12'h50C, 2'd2, 0);

        // R7 ordinary store clears all matching
        for (int c = 0; c < 3; c++) req("R1", c, 12'h600 + 12'(c * 4), 2'd1, 0);
        req("R1", 3, 12'h610, 2'd1, 0);
        req("R7 plain store writes", 0, 12'h605, 2'd3, 0);
        req("R7 cleared by store", 1, 12'h600, 2'd2, 0);
        req("R7 cleared issuer ctx", 0, 12'h600, 2'd2, 0);
        req("R7 other granule kept", 3, 12'h610, 2'd2, 0);

        // R6 uncacheable
        req("R1", 1, 12'h700, 2'd1, 0);
        req("R6 uncached writes, no result", 0, 12'h708, 2'd2, 1);
        req("R6 uncached invalidates", 1, 12'h700, 2'd2, 0);
        for (int i = 0; i < 3; i++) req("R4 build failures", 2, 12'h000, 2'd2, 0);
        req("R6 uncached resets count", 2, 12'h000, 2'd2, 1);
        for (int i = 0; i < 5; i++) req("R6 R8 count restarted", 2, 12'h000, 2'd2, 0);

        // R8 warning period, R5 reset on pass
        for (int i = 0; i < 12; i++) req("R8 warn on multiple", 3, 12'h800, 2'd2, 0);
        for (int i = 0; i < 3; i++) req("R4", 1, 12'h800, 2'd2, 0);
        req("R1", 1, 12'h900, 2'd1, 0);
        req("R5 pass resets count", 1, 12'h900, 2'd2, 0);
        for (int i = 0; i < 5; i++) req("R5 R8 count from zero", 1, 12'h800, 2'd2, 0);

        // R10 other op and idle cycles
        req("R1", 0, 12'hA00, 2'd1, 0);
        req("R10 other op ignored", 1, 12'hA00, 2'd0, 0);
        @(negedge clk);
        check("R10 idle quiet", {sc_valid, wr_en, warn}, 3'b000);
        req("R10 reservation kept", 0, 12'hA00, 2'd2, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule